// File: doc/BRIEF.md
# Cumulative Distribution Table Builder

This block owns a memory of 2^ADDR_W words of DATA_W bits (1024 x 24 by default) and turns a histogram held in it into a cumulative distribution. An internal address counter walks the memory from the first location to the last. Each location is replaced by the sum of its own contents and the contents of every earlier location. The finished table can then serve as the mapping for histogram equalization.

The same counter serves a second mode that loads the table. In that mode, words on the data input are written to consecutive locations. The output bus shows each location's contents before it is overwritten, so a load pass also reads back the table that was there before it. A run is controlled by an active-low start strobe. The mode input is taken only while the strobe is high.

The controller is a three-state machine:
- `ST_IDLE`: the strobe is high or has just been released.
- `ST_RUN`: the counter is issuing addresses.
- `ST_DONE`: the last address has been issued and the counter is parked.

Its transitions are:
- `ST_IDLE` to `ST_RUN` on the first clock edge where the strobe is sampled low. Address 0 is issued on that edge.
- `ST_RUN` to `ST_RUN` on each further low sample, issuing the next address.
- `ST_RUN` to `ST_DONE` on the edge that issues the last address.
- `ST_RUN` or `ST_DONE` to `ST_IDLE` when the strobe is sampled high.

Every issued address, together with its data word, is carried through three pipeline registers. The memory update happens on the third edge after the issue.

Top module: `cdt_builder`

## Requirements
- R1: After reset, `dout` is 0 and stays 0 until the first memory update.
- R2: On the first rising edge where `start_n` is sampled low, the counter restarts at address 0. The running sum starts from zero, so in accumulate mode location 0 is written back with its own contents and `dout` shows that value.
- R3: In accumulate mode (`mode_load` = 0), each address issued while `start_n` is low (0, 1, 2, ... in order) is replaced by its contents plus the running sum of all earlier locations of the run. `dout` shows that new value. An address issued on rising edge k is written, and shown on `dout`, on rising edge k+3.
- R4: In load mode (`mode_load` = 1), the `din` word sampled on rising edge k (with `start_n` low) is written at edge k+3 to the address issued at edge k. On that same edge, `dout` shows the location's previous contents.
- R5: Once address 2^ADDR_W-1 has been issued, the counter holds and no further location is written while `start_n` stays low. `dout` then holds its last value.
- R6: When `start_n` is sampled high, no new address is issued. Only the up to three updates already in the pipeline complete, and `dout` then holds its last value.
- R7: `mode_load` is taken only on edges where `start_n` is high. Changing it while `start_n` is low does not alter the mode of the current run.
- R8: A run that was stopped part way restarts at address 0 when `start_n` is next sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control and pipeline |
| start_n | input | 1 | Active-low run strobe |
| mode_load | input | 1 | 0 = running-sum accumulate, 1 = sequential table load |
| din | input | DATA_W | Table word for load mode |
| dout | output | DATA_W | Running sum (accumulate) or previous contents (load) |

## Verification
Every memory update, and the `dout` value that goes with it, is due on the third rising edge after the edge that issued its address. The bench drives each input on a falling edge. It then checks `dout` on the falling edge that follows the third rising edge after the issue. Once the last issued update is past, it checks on every cycle that `dout` holds. Saturation, partial stops and the choice of mode are checked again by a later load pass, which reads back the whole table through the previous-contents output.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cdt_state_e;

    localparam logic MODE_ACC  = 1'b0;
    localparam logic MODE_LOAD = 1'b1;

    localparam int PIPE_STAGES = 3;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              mode_in,
    output logic              issue,
    output logic              issue_first,
    output logic              issue_mode,
    output logic [ADDR_W-1:0] issue_addr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [ADDR_W-1:0] ONE_ADDR  = ADDR_W'(1);

    cdt_state_e        state, state_n;
    logic [ADDR_W-1:0] cnt, cnt_n;
    logic              mode_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= MODE_ACC;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (start_n) mode_q <= mode_in;
        end
    end

    // next state and counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (!start_n) begin
                    state_n = ST_RUN;
                    cnt_n   = ONE_ADDR;
                end
            end
            ST_RUN: begin
                if (start_n) begin
                    state_n = ST_IDLE;
                end else if (cnt == LAST_ADDR) begin
                    state_n = ST_DONE;
                end else begin
                    cnt_n = cnt + ONE_ADDR;
                end
            end
            ST_DONE: begin
                if (start_n) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue       = 1'b0;
        issue_first = 1'b0;
        issue_addr  = cnt;
        issue_mode  = mode_q;
        unique case (state)
            ST_IDLE: begin
                issue       = !start_n;
                issue_first = 1'b1;
                issue_addr  = '0;
            end
            ST_RUN:  issue = !start_n;
            ST_DONE: issue = 1'b0;
            default: issue = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdt_delay.sv
module cdt_delay #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cdt_mem.sv
module cdt_mem
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_first,
    input  logic              wr_mode,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] table_q [DEPTH];
    logic [DATA_W-1:0] run_sum;
    logic [DATA_W-1:0] old_word, base, acc;

    always_comb begin
        old_word = table_q[wr_addr];
        base     = wr_first ? '0 : run_sum;
        acc      = base + old_word;
    end

    always_ff @(posedge clk) begin
        if (wr_en) table_q[wr_addr] <= (wr_mode == MODE_LOAD) ? wr_data : acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_sum <= '0;
            dout    <= '0;
        end else if (wr_en) begin
            if (wr_mode == MODE_LOAD) begin
                dout <= old_word;
            end else begin
                dout    <= acc;
                run_sum <= acc;
            end
        end
    end
endmodule

// File: rtl/cdt_builder.sv
module cdt_builder
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              mode_load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int ENTRY_W = 3 + ADDR_W + DATA_W;

    logic              issue, issue_first, issue_mode;
    logic [ADDR_W-1:0] issue_addr;
    logic [ENTRY_W-1:0] entry_in, entry_out;
    logic              wr_en, wr_first, wr_mode;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    cdt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_n     (start_n),
        .mode_in     (mode_load),
        .issue       (issue),
        .issue_first (issue_first),
        .issue_mode  (issue_mode),
        .issue_addr  (issue_addr)
    );

    assign entry_in = {issue, issue_first, issue_mode, issue_addr, din};

    cdt_delay #(.WIDTH(ENTRY_W), .STAGES(PIPE_STAGES)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (entry_in),
        .q     (entry_out)
    );

    assign {wr_en, wr_first, wr_mode, wr_addr, wr_data} = entry_out;

    cdt_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_first (wr_first),
        .wr_mode  (wr_mode),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dout     (dout)
    );
endmodule

// File: rtl/cdt_builder_chk.sv
module cdt_builder_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_n,
    input logic              issue,
    input logic [ADDR_W-1:0] issue_addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] dout
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_n) && !start_n) |-> (issue && issue_addr == '0));

    assert_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue) && issue) |-> (issue_addr == $past(issue_addr) + 1'b1));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && issue_addr == LAST_ADDR) |=> !issue);

    assert_no_issue_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_n |-> !issue);

    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dout));
endmodule

bind cdt_builder cdt_builder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_n    (start_n),
    .issue      (issue),
    .issue_addr (issue_addr),
    .wr_en      (wr_en),
    .dout       (dout)
);

// File: tb/tb_cdt_builder.sv
module tb_cdt_builder;
    localparam int AW    = 10;
    localparam int DW    = 24;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_n = 1'b1;
    logic          mode_load = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] model [DEPTH];
    bit            known [DEPTH];
    logic [DW-1:0] exp_v [DEPTH];
    bit            exp_k [DEPTH];

    cdt_builder #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (start_n),
        .mode_load (mode_load),
        .din       (din),
        .dout      (dout)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int s, input int t);
        int v;
        v = ((t * 29 + s * 53 + (t >> 4)) & 255) + 1;
        return DW'(v);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One pass of the strobe low for n_low cycles, then high for six cycles.
    task automatic run_pass(input bit load, input int n_low, input int seed,
                            input bit flip, input bit chk, input string rq);
        int            issued;
        logic [DW-1:0] run;
        bit            allk;
        issued = (n_low > DEPTH) ? DEPTH : n_low;
        run  = '0;
        allk = 1'b1;
        for (int i = 0; i < issued; i++) begin
            if (load) begin
                exp_v[i] = model[i];
                exp_k[i] = known[i];
                model[i] = pat(seed, i);
                known[i] = 1'b1;
            end else begin
                allk     = allk & known[i];
                run      = run + model[i];
                exp_v[i] = run;
                exp_k[i] = allk;
                model[i] = run;
                known[i] = allk;
            end
        end
        mode_load = load;
        start_n   = 1'b1;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        for (int t = 0; t < n_low + 6; t++) begin
            start_n = (t < n_low) ? 1'b0 : 1'b1;
            din     = pat(seed, t);
            if (flip && t > 0) mode_load = !load;
            @(posedge clk);
            @(negedge clk);
            if (chk && t >= 3) begin
                if (t - 3 < issued) begin
                    if (exp_k[t-3])
                        check((t == 3 && !load) ? "R2 first location" : rq, dout, exp_v[t-3]);
                end else if (exp_k[issued-1]) begin
                    check((n_low > DEPTH) ? "R5 hold after last address" : "R6 hold after strobe high",
                          dout, exp_v[issued-1]);
                end
            end
        end
        mode_load = load;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output", dout, '0);
        repeat (2) @(negedge clk);
        check("R1 output idle", dout, '0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        run_pass(1'b1, DEPTH, 1, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_load_saturate;
        run_pass(1'b1, DEPTH + 6, 2, 1'b0, 1'b1, "R4 load previous contents");
    endtask

    task automatic t_accumulate_full;
        run_pass(1'b0, DEPTH + 6, 0, 1'b0, 1'b1, "R3 running sum");
    endtask

    task automatic t_readback_flip;
        run_pass(1'b1, DEPTH, 3, 1'b1, 1'b1, "R7 mode held while strobe low");
    endtask

    task automatic t_partial_restart;
        run_pass(1'b0, 10, 0, 1'b0, 1'b1, "R6 partial run");
        run_pass(1'b0, 5, 0, 1'b1, 1'b1, "R8 restart at zero");
    endtask

    task automatic t_final_readback;
        run_pass(1'b1, DEPTH, 4, 1'b0, 1'b1, "R6 untouched locations");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill();
        t_load_saturate();
        t_accumulate_full();
        t_readback_flip();
        t_partial_restart();
        t_final_readback();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule